// File: doc/BRIEF.md
# Two-Wire Serial Status and Counter Core

This block is the status and timing heart of a small serial port that runs either as a two-wire bus agent or as a three-wire clocked shifter. It samples the clock line and the data line through synchronizers. It finds start and stop conditions and counts every clock edge on a 4-bit counter. It also keeps an 8-bit data shift register and an 8-bit buffer that captures the data register when a transfer finishes.

The CPU reads one status byte. That byte holds three sticky event flags, a live collision bit and the counter value. The CPU clears a flag by writing a one to its bit, and it loads the counter by writing the low four bits. In two-wire mode, a pending start or overflow flag stretches the clock line low until software clears it. Two interrupt requests come from the start and overflow flags, each gated by its own enable.

Top module: `serial_status_core`

## Requirements
- R1: After reset the three flags, the counter, the data register and the buffer are all 0. With three-wire mode selected, the status byte then reads 0x00 and the stretch and interrupt outputs are low.
- R2: In two-wire mode, the start flag (status bit 7) sets when SDA falls while SCL is high. The stop flag (status bit 5) sets when SDA rises while SCL is high.
- R3: Outside two-wire mode, every SCL edge, rising or falling, sets the start flag. SDA changes never set the start or stop flag. The collision bit reads 0.
- R4: A status write with a 1 in bit 7, 6 or 5 clears that flag, and a 0 leaves it unchanged. If a flag's set event and its clear arrive in the same cycle, the flag ends up set.
- R5: Status bits 3:0 show the counter. It adds one on every SCL edge, rising or falling. A status write loads it from write bits 3:0, and that load wins over a coincident edge.
- R6: The overflow flag (status bit 6) sets when an edge takes the counter from 15 to 0. It does not set when a status write lands in the same cycle.
- R7: On that same 15-to-0 wrap, the buffer takes the value that the data register holds at the end of the cycle.
- R8: In two-wire mode, the stretch output is high while the start flag or the overflow flag is set. It drops once both are cleared. Outside two-wire mode it stays low.
- R9: In two-wire mode, the collision bit (status bit 4) equals data register bit 7 XOR the synchronized SDA level. Writes to bit 4 are ignored.
- R10: The start interrupt is the start flag AND its enable. The overflow interrupt is the overflow flag AND its enable. The stop flag drives neither.
- R11: A data write loads the data register. On each SCL rising edge the register shifts left, with the synchronized SDA entering bit 0. A data write wins over a coincident shift.
- R12: A pin change takes effect on the third rising clock edge after it is applied: two synchronizer stages and one edge-detect register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_pin | input | 1 | Asynchronous clock-line level |
| sda_pin | input | 1 | Asynchronous data-line level |
| two_wire | input | 1 | 1 selects two-wire mode; 0 selects three-wire or output-disabled |
| start_ie | input | 1 | Start interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status write data |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data register write data |
| stat_rdata | output | 8 | Status byte: start, overflow, stop, collision, counter |
| data_rdata | output | 8 | Data shift register |
| buf_rdata | output | 8 | Buffer register |
| scl_hold_low | output | 1 | Request to hold the clock line low |
| start_irq | output | 1 | Start interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
On every cycle, the assertions check the following:
- the stretch output against pending flags and mode;
- that the collision bit and stop flag stay quiet outside two-wire mode;
- that a stop flag persists until cleared;
- that the counter only ever moves by one step unless written;
- that each wrap both raises the overflow flag and fills the buffer;
- that interrupts never fire without their flag and enable.

Other behaviours need the bench's scenarios: the exact synchronizer latency, a write colliding with a counter edge or a flag event, the shifted data values, and the start or stop decoding of particular line sequences.

// File: rtl/ssc_pkg.sv
`timescale 1ns/1ps
package ssc_pkg;
  // Event flag indices inside the flag vector (vector sits at the top of the status byte)
  localparam int NUM_FLAGS  = 3;
  localparam int FLAG_START = 2;
  localparam int FLAG_OVF   = 1;
  localparam int FLAG_STOP  = 0;
  // One collision bit sits between the flags and the counter
  localparam int COLL_BITS  = 1;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } line_evt_t;
endpackage

// File: rtl/ssc_line_sync.sv
`timescale 1ns/1ps
module ssc_line_sync import ssc_pkg::*; #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pin,
  output line_evt_t evt
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{IDLE_LV}};
      last_q  <= IDLE_LV;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign evt.lvl  = chain_q[STAGES-1];
  assign evt.rise = chain_q[STAGES-1] & ~last_q;
  assign evt.fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/ssc_edge_counter.sv
`timescale 1ns/1ps
module ssc_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // a CPU load overrides the step, so no wrap is reported then
  assign wrap = step & ~load & (cnt_q == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssc_shift_buf.sv
`timescale 1ns/1ps
module ssc_shift_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              shift_in,
  input  logic              capture,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] buf_q
);
  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = data_q;
    if (load)       data_d = load_val;
    else if (shift) data_d = {data_q[DATA_W-2:0], shift_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      buf_q  <= '0;
    end else begin
      data_q <= data_d;
      if (capture) buf_q <= data_d;
    end
  end
endmodule

// File: rtl/ssc_flags.sv
`timescale 1ns/1ps
module ssc_flags import ssc_pkg::*; (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_FLAGS-1:0] set_evt,
  input  logic                 clr_en,
  input  logic [NUM_FLAGS-1:0] clr_mask,
  output logic [NUM_FLAGS-1:0] flag_q
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic q;
    // a set event beats a same-cycle clear so no event is lost
    always_ff @(posedge clk) begin
      if (rst)                       q <= 1'b0;
      else if (set_evt[i])           q <= 1'b1;
      else if (clr_en && clr_mask[i]) q <= 1'b0;
    end
    assign flag_q[i] = q;
  end
endmodule

// File: rtl/serial_status_core.sv
`timescale 1ns/1ps
module serial_status_core import ssc_pkg::*; #(
  parameter int  CNT_W       = 4,
  parameter int  DATA_W      = 8,
  parameter int  SYNC_STAGES = 2,
  localparam int STAT_W      = NUM_FLAGS + COLL_BITS + CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_pin,
  input  logic              sda_pin,
  input  logic              two_wire,
  input  logic              start_ie,
  input  logic              ovf_ie,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [STAT_W-1:0] stat_rdata,
  output logic [DATA_W-1:0] data_rdata,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              scl_hold_low,
  output logic              start_irq,
  output logic              ovf_irq
);
  line_evt_t scl_e, sda_e;
  logic [CNT_W-1:0]     cnt;
  logic                 wrap;
  logic [NUM_FLAGS-1:0] flags, set_evt;
  logic                 scl_edge, collision;
  logic                 unused_coll_wbit;

  ssc_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .pin(scl_pin), .evt(scl_e));
  ssc_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .pin(sda_pin), .evt(sda_e));

  assign scl_edge = scl_e.rise | scl_e.fall;

  ssc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(scl_edge), .load(stat_wr),
    .load_val(stat_wdata[CNT_W-1:0]), .cnt_q(cnt), .wrap(wrap));

  ssc_shift_buf #(.DATA_W(DATA_W)) u_dbuf (
    .clk(clk), .rst(rst), .load(data_wr), .load_val(data_wdata),
    .shift(scl_e.rise), .shift_in(sda_e.lvl), .capture(wrap),
    .data_q(data_rdata), .buf_q(buf_rdata));

  always_comb begin
    set_evt             = '0;
    set_evt[FLAG_START] = two_wire ? (sda_e.fall & scl_e.lvl) : scl_edge;
    set_evt[FLAG_STOP]  = two_wire & sda_e.rise & scl_e.lvl;
    set_evt[FLAG_OVF]   = wrap;
  end

  ssc_flags u_flags (
    .clk(clk), .rst(rst), .set_evt(set_evt), .clr_en(stat_wr),
    .clr_mask(stat_wdata[STAT_W-1 -: NUM_FLAGS]), .flag_q(flags));

  assign collision        = two_wire & (data_rdata[DATA_W-1] ^ sda_e.lvl);
  assign unused_coll_wbit = stat_wdata[CNT_W];
  assign stat_rdata       = {flags, collision, cnt};
  assign scl_hold_low     = two_wire & (flags[FLAG_START] | flags[FLAG_OVF]);
  assign start_irq        = flags[FLAG_START] & start_ie;
  assign ovf_irq          = flags[FLAG_OVF] & ovf_ie;
endmodule

// File: rtl/ssc_checker.sv
`timescale 1ns/1ps
module ssc_checker #(
  parameter int  CNT_W  = 4,
  parameter int  DATA_W = 8,
  localparam int STAT_W = CNT_W + 4
) (
  input logic              clk,
  input logic              rst,
  input logic              two_wire,
  input logic              start_ie,
  input logic              ovf_ie,
  input logic              stat_wr,
  input logic              stop_clr,
  input logic [STAT_W-1:0] stat_rdata,
  input logic [DATA_W-1:0] data_rdata,
  input logic [DATA_W-1:0] buf_rdata,
  input logic              scl_hold_low,
  input logic              start_irq,
  input logic              ovf_irq
);
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t CNT_TOP = '1;

  logic f_start, f_ovf, f_stop, f_coll;
  cnt_t cnt_now;
  assign f_start = stat_rdata[STAT_W-1];
  assign f_ovf   = stat_rdata[STAT_W-2];
  assign f_stop  = stat_rdata[STAT_W-3];
  assign f_coll  = stat_rdata[STAT_W-4];
  assign cnt_now = stat_rdata[CNT_W-1:0];

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (two_wire && (f_start || f_ovf)) |-> scl_hold_low);
  assert_no_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !two_wire |-> !scl_hold_low);
  assert_coll_off_R3: assert property (@(posedge clk) disable iff (rst)
    !two_wire |-> !f_coll);
  assert_stop_mode_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(f_stop) |-> $past(two_wire));
  assert_stop_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (f_stop && !(stat_wr && stop_clr)) |=> f_stop);
  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(stat_wr) && (cnt_now != $past(cnt_now))) |-> (cnt_now == cnt_t'($past(cnt_now) + 1'b1)));
  assert_ovf_on_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(stat_wr) && ($past(cnt_now) == CNT_TOP) && (cnt_now == '0)) |-> f_ovf);
  assert_buf_on_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(stat_wr) && ($past(cnt_now) == CNT_TOP) && (cnt_now == '0)) |-> (buf_rdata == data_rdata));
  assert_start_irq_R10: assert property (@(posedge clk) disable iff (rst)
    start_irq |-> (f_start && start_ie));
  assert_ovf_irq_R10: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (f_ovf && ovf_ie));
endmodule

bind serial_status_core ssc_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .two_wire(two_wire), .start_ie(start_ie), .ovf_ie(ovf_ie),
  .stat_wr(stat_wr), .stop_clr(stat_wdata[STAT_W-3]), .stat_rdata(stat_rdata),
  .data_rdata(data_rdata), .buf_rdata(buf_rdata), .scl_hold_low(scl_hold_low),
  .start_irq(start_irq), .ovf_irq(ovf_irq));

// File: tb/serial_status_core_test.sv
`timescale 1ns/1ps
module serial_status_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_pin = 1'b1, sda_pin = 1'b1, two_wire = 1'b0;
  logic start_ie = 1'b0, ovf_ie = 1'b0, stat_wr = 1'b0, data_wr = 1'b0;
  logic [7:0] stat_wdata = '0, data_wdata = '0;
  logic [7:0] stat_rdata, data_rdata, buf_rdata;
  logic scl_hold_low, start_irq, ovf_irq;

  int n_checks = 0;
  int n_fails  = 0;

  // bench-side expected state
  logic m_start = 0, m_ovf = 0, m_stop = 0, m_two = 0, m_scl = 1, m_sda = 1;
  logic [3:0] m_cnt = 0;
  logic [7:0] m_dr = 0, m_buf = 0;

  always #2 clk = ~clk;

  serial_status_core uut (
    .clk(clk), .rst(rst), .scl_pin(scl_pin), .sda_pin(sda_pin), .two_wire(two_wire),
    .start_ie(start_ie), .ovf_ie(ovf_ie), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .stat_rdata(stat_rdata),
    .data_rdata(data_rdata), .buf_rdata(buf_rdata), .scl_hold_low(scl_hold_low),
    .start_irq(start_irq), .ovf_irq(ovf_irq));

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_coll();
    return m_two && (m_dr[7] ^ m_sda);
  endfunction

  task automatic model_scl(logic v);
    logic [7:0] nxt;
    nxt = m_dr;
    if (v) nxt = {m_dr[6:0], m_sda};
    if (m_cnt == 4'hF) begin m_ovf = 1; m_buf = nxt; end
    m_cnt = m_cnt + 1'b1;
    m_dr  = nxt;
    if (!m_two) m_start = 1;
    m_scl = v;
  endtask

  task automatic model_sda(logic v);
    if (m_two && m_scl) begin
      if (!v) m_start = 1; else m_stop = 1;
    end
    m_sda = v;
  endtask

  task automatic model_stat_wr(logic [7:0] v);
    if (v[7]) m_start = 0;
    if (v[6]) m_ovf = 0;
    if (v[5]) m_stop = 0;
    m_cnt = v[3:0];
  endtask

  task automatic check_all();
    string ts;
    ts = m_two ? "R2" : "R3";
    chk({ts, " start"}, stat_rdata[7], m_start);
    chk("R6 ovf", stat_rdata[6], m_ovf);
    chk({ts, " stop"}, stat_rdata[5], m_stop);
    chk("R9 coll", stat_rdata[4], exp_coll());
    chk("R5 cnt", stat_rdata[3:0], m_cnt);
    chk("R11 data", data_rdata, m_dr);
    chk("R7 buf", buf_rdata, m_buf);
    chk("R8 hold", scl_hold_low, m_two && (m_start || m_ovf));
    chk("R10 start irq", start_irq, m_start && start_ie);
    chk("R10 ovf irq", ovf_irq, m_ovf && ovf_ie);
  endtask

  // all tasks enter and leave at a falling clock edge
  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic drive_scl(logic v);
    scl_pin = v; model_scl(v); settle(); check_all();
  endtask

  task automatic drive_sda(logic v);
    sda_pin = v; model_sda(v); settle(); check_all();
  endtask

  task automatic wr_stat(logic [7:0] v);
    stat_wr = 1; stat_wdata = v;
    @(negedge clk);
    stat_wr = 0; model_stat_wr(v); check_all();
  endtask

  task automatic wr_data(logic [7:0] v);
    data_wr = 1; data_wdata = v;
    @(negedge clk);
    data_wr = 0; m_dr = v; check_all();
  endtask

  task automatic set_mode(logic v);
    two_wire = v; m_two = v;
    @(negedge clk); check_all();
  endtask

  task automatic random_ops(int n);
    for (int i = 0; i < n; i++) begin
      case ($urandom_range(0, 9))
        0, 1, 2, 3: drive_scl(~m_scl);
        4, 5, 6:    drive_sda(~m_sda);
        7:          wr_stat(8'($urandom));
        8:          wr_data(8'($urandom));
        default: begin
          start_ie = 1'($urandom_range(0, 1));
          ovf_ie   = 1'($urandom_range(0, 1));
          @(negedge clk); check_all();
        end
      endcase
    end
  endtask

  initial begin
    #400000;
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0] wv;
    void'($urandom(32'd2718));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state with three-wire mode selected
    chk("R1 status", stat_rdata, 8'h00);
    chk("R1 data", data_rdata, 8'h00);
    chk("R1 buf", buf_rdata, 8'h00);
    chk("R1 hold", scl_hold_low, 0);
    chk("R1 irqs", {start_irq, ovf_irq}, 0);

    set_mode(1);
    start_ie = 1; ovf_ie = 1;
    drive_sda(0);                    // R2 start condition
    wr_stat({3'b100, 1'b0, m_cnt});  // clear start, R8 release
    drive_sda(1);                    // R2 stop condition
    chk("R10 stop raises no irq", {start_irq, ovf_irq}, 0);

    // R12 latency, then R4 set-wins-over-clear
    sda_pin = 0;
    repeat (2) @(negedge clk);
    chk("R12 not yet after two edges", stat_rdata[7], 0);
    wv = {3'b100, 1'b0, m_cnt};
    stat_wr = 1; stat_wdata = wv;
    @(negedge clk);
    stat_wr = 0;
    chk("R12 set on third edge / R4 set wins", stat_rdata[7], 1);
    model_stat_wr(wv); model_sda(0); check_all();

    wr_stat({4'b0001, m_cnt});        // R4 zeros leave flags
    chk("R4 zero write keeps start", stat_rdata[7], 1);
    wr_stat({4'b1110, m_cnt});        // R4 clear all
    chk("R8 hold released", scl_hold_low, 0);

    // R6 / R7 wrap with a rising edge
    wr_data(8'hA5);
    wr_stat(8'h0E);
    drive_scl(0);
    drive_scl(1);
    chk("R7 buffer holds shifted value", buf_rdata, 8'h4A);

    // R5 / R6 write wins over coincident edge at 15
    wr_stat(8'hEF);
    scl_pin = 0;
    repeat (2) @(negedge clk);
    stat_wr = 1; stat_wdata = 8'h05;
    @(negedge clk);
    stat_wr = 0;
    m_scl = 0; model_stat_wr(8'h05);
    chk("R5 write wins over edge", stat_rdata[3:0], 4'h5);
    chk("R6 no ovf when write coincides", stat_rdata[6], 0);
    check_all();
    drive_scl(1);

    random_ops(200);

    // R3 three-wire directed
    set_mode(0);
    wr_stat(8'hE0);
    drive_sda(~m_sda);
    chk("R3 sda ignored for start", stat_rdata[7], 0);
    drive_scl(0);
    chk("R3 scl edge sets start", stat_rdata[7], 1);
    chk("R3 no hold", scl_hold_low, 0);
    random_ops(150);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end
endmodule